// File: doc/BRIEF.md
# Dual-Channel Programmable Down-Counting Timer

This block holds two independent down-counters, each driven by its own clock divider, behind a small 32-bit register interface. Software programs a start value and a control word for each channel. A running channel fires once (single-shot) or repeatedly (auto-reload). Each expiry sets a sticky flag in a shared status word. Software clears that flag by writing a one to its bit.

Each channel has one level interrupt output. It is high while the channel's flag is set and its interrupt enable is on. Only channel 1 exposes its live count for reading, so it can act as a free-running time base. Channel 0 is meant for event timing.

Writes are single-cycle: when `wr_en` is high at a rising clock edge, `wdata` goes to the byte address `addr`. Reads are combinational. `rdata` always shows the register that `addr` selects. Reset is synchronous and active high.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: Address 0x00 (channel 0) and address 0x04 (channel 1) hold the control words. Bit 30 is run, bit 29 is interrupt enable, bits 28:27 are the mode and bits 7:0 are the divider setting. Addresses 0x08 and 0x0C hold the 24-bit start values of channels 0 and 1. All these read back as written, and unused bits read zero.
- R3: While run is set, a channel advances once every divider+1 clocks. A divider of 0 advances every clock.
- R4: On the first advance after run is set on an idle channel, its counter loads the start value. Each later advance subtracts one. Address 0x14 returns channel 1's live count in bits 23:0.
- R5: In mode 01 (auto-reload), the channel expires on an advance that finds the count at 1 or 0. It then reloads the start value and keeps running, so expiries are start × (divider+1) clocks apart.
- R6: In any other mode (single-shot), expiry leaves the count at 0 and the channel idle, and clears the run bit. A control write in that same cycle takes precedence over this clearing.
- R7: Address 0x18 holds the status flags: bit 0 for channel 0 and bit 1 for channel 1. An expiry sets its flag whatever the interrupt enable is. Writing 1 to a bit clears that flag. If a flag is set and cleared in the same cycle, the set wins.
- R8: `irq[i]` is high exactly when flag i and channel i's interrupt enable are both set.
- R9: Clearing run freezes both the count and the divider phase. Setting run again continues from the frozen values.
- R10: Writing a start value while the channel counts leaves the current count alone. The new value is used at the next load or reload.
- R11: Writes to any other address are ignored, and reads of it return zero.
- R12: Activity on one channel never changes the other channel's count, flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| addr | input | ADDR_W (8) | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 2 | Level interrupt per channel |

## Verification
The embedded properties check, on every cycle, the following:
- an expiry always leaves its flag set on the next cycle, even if a clear was written in the same cycle;
- an auto-reload expiry reloads the start value that was in place at that edge;
- a single-shot expiry parks the channel at zero and drops run unless a write intervened;
- a stopped channel's count never moves;
- the divider never produces two back-to-back advances for a nonzero setting.

Expiry spacing, readback encodings, the effect of reserved addresses, and the independence of the two channels under mixed, randomly interleaved writes can only be shown by the bench's scenarios. Its cycle model is compared with the read port and interrupts on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word field positions (decoded by software)
  localparam int RUN_BIT  = 30;
  localparam int IEN_BIT  = 29;
  localparam int MODE_LO  = 27;
  localparam logic [1:0] MODE_RELOAD = 2'b01;

  // byte offsets of the register map
  localparam int OFF_CTRL0 = 'h00;
  localparam int OFF_CTRL1 = 'h04;
  localparam int OFF_INIT0 = 'h08;
  localparam int OFF_INIT1 = 'h0C;
  localparam int OFF_LIVE1 = 'h14;
  localparam int OFF_FLAGS = 'h18;

  function automatic logic reload_mode(input logic [1:0] mode);
    return mode == MODE_RELOAD;
  endfunction

  // an advance that finds the count at or below one ends the period
  function automatic logic period_done(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

  function automatic logic [31:0] flag_next(input logic [31:0] cur, input logic [31:0] hit,
                                            input logic [31:0] wipe);
    return hit | (cur & ~wipe);
  endfunction
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = run && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (run) begin
      if (tick) phase_q <= '0;
      else      phase_q <= phase_q + 1'b1;
    end
  end

  // R3: a nonzero divider setting never advances on two adjacent clocks
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && limit != '0) |=> (!tick || limit == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic             init_wr,
  input  logic [31:0]      wdata,
  output logic [31:0]      ctrl_rd,
  output logic [31:0]      init_rd,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             int_en
);
  logic             run_q, ien_q, loaded_q;
  logic [1:0]       mode_q;
  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] init_q, count_q;
  logic             tick, reload;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;

  tmr_divider #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst(rst), .run(run_q), .limit(div_q), .tick(tick)
  );

  assign reload = reload_mode(mode_q);
  assign expire = tick && loaded_q && period_done(32'(count_q));
  assign count  = count_q;
  assign int_en = ien_q;
  assign init_rd = 32'(init_q);

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[RUN_BIT] = run_q;
    ctrl_rd[IEN_BIT] = ien_q;
    ctrl_rd[MODE_LO +: 2] = mode_q;
    ctrl_rd[PRE_W-1:0] = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      ien_q    <= 1'b0;
      mode_q   <= '0;
      div_q    <= '0;
      init_q   <= '0;
      count_q  <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= wdata[RUN_BIT];
        ien_q  <= wdata[IEN_BIT];
        mode_q <= wdata[MODE_LO +: 2];
        div_q  <= wdata[PRE_W-1:0];
      end else if (expire && !reload) begin
        run_q <= 1'b0;
      end
      if (init_wr) init_q <= wdata[CNT_W-1:0];
      if (tick) begin
        if (!loaded_q) begin
          count_q  <= init_q;
          loaded_q <= 1'b1;
        end else if (expire) begin
          if (reload) begin
            count_q <= init_q;
          end else begin
            count_q  <= '0;
            loaded_q <= 1'b0;
          end
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
    end
  end

  // R9: a stopped channel holds its count
  p_hold_stopped_r9: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> $stable(count_q));
  // R5: auto-reload expiry restarts from the start value of that edge
  p_reload_value_r5: assert property (@(posedge clk) disable iff (rst)
    (expire && reload) |=> count_q == $past(init_q));
  // R6: single-shot expiry parks at zero, idle
  p_single_park_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !reload) |=> (count_q == '0 && !loaded_q));
  // R6: and drops run unless software wrote the control word
  p_single_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !reload && !ctrl_wr) |=> !run_q);
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [1:0]        irq
);
  localparam int NCH = 2;
  localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(OFF_CTRL0);
  localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFF_CTRL1);
  localparam logic [ADDR_W-1:0] A_INIT0 = ADDR_W'(OFF_INIT0);
  localparam logic [ADDR_W-1:0] A_INIT1 = ADDR_W'(OFF_INIT1);
  localparam logic [ADDR_W-1:0] A_LIVE1 = ADDR_W'(OFF_LIVE1);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFF_FLAGS);

  logic [31:0]      ctrl_v [NCH];
  logic [31:0]      init_v [NCH];
  logic [CNT_W-1:0] cnt_v  [NCH];
  logic [NCH-1:0]   expire, ien, ctrl_wr, init_wr;
  logic [NCH-1:0]   flags_q;
  logic             flags_wr;
  logic [31:0]      flags_nx;
  logic             unused_cnt0;

  assign unused_cnt0 = ^cnt_v[0];
  assign flags_wr = wr_en && addr == A_FLAGS;
  assign ctrl_wr  = {wr_en && addr == A_CTRL1, wr_en && addr == A_CTRL0};
  assign init_wr  = {wr_en && addr == A_INIT1, wr_en && addr == A_INIT0};
  assign flags_nx = flag_next(32'(flags_q), 32'(expire), flags_wr ? wdata : 32'd0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr[i]), .init_wr(init_wr[i]),
      .wdata(wdata), .ctrl_rd(ctrl_v[i]), .init_rd(init_v[i]),
      .count(cnt_v[i]), .expire(expire[i]), .int_en(ien[i])
    );

    // R7: an expiry is never lost, even against a clear in the same cycle
    p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
      expire[i] |=> flags_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_nx[NCH-1:0];
  end

  assign irq = flags_q & ien;

  always_comb begin
    case (addr)
      A_CTRL0: rdata = ctrl_v[0];
      A_CTRL1: rdata = ctrl_v[1];
      A_INIT0: rdata = init_v[0];
      A_INIT1: rdata = init_v[1];
      A_LIVE1: rdata = 32'(cnt_v[1]);
      A_FLAGS: rdata = 32'(flags_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_tick_timer_pair.sv
module sim_tick_timer_pair;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst = 1, b_wr = 0;
  logic [7:0]  b_addr = 0;
  logic [31:0] b_wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  tick_timer_pair u0 (.clk(clk), .rst(rst), .wr_en(b_wr), .addr(b_addr),
                      .wdata(b_wdata), .rdata(rdata), .irq(irq));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // behavioural model state
  int m_run[2], m_ien[2], m_mode[2], m_div[2], m_ph[2], m_init[2], m_cnt[2], m_busy[2], m_flag[2];

  function automatic int unsigned model_read(input int a);
    int unsigned v;
    v = 0;
    if (a == 0 || a == 4) begin
      int c = a / 4;
      v = (m_run[c] << 30) | (m_ien[c] << 29) | (m_mode[c] << 27) | m_div[c];
    end else if (a == 8 || a == 12) v = m_init[(a - 8) / 4];
    else if (a == 'h14) v = m_cnt[1];
    else if (a == 'h18) v = m_flag[0] | (m_flag[1] << 1);
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_run[c] = 0; m_ien[c] = 0; m_mode[c] = 0; m_div[c] = 0; m_ph[c] = 0;
        m_init[c] = 0; m_cnt[c] = 0; m_busy[c] = 0; m_flag[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit adv, fin;
        adv = m_run[c] != 0 && m_ph[c] >= m_div[c];
        fin = adv && m_busy[c] != 0 && m_cnt[c] <= 1;
        if (m_run[c] != 0) m_ph[c] = adv ? 0 : m_ph[c] + 1;
        if (adv) begin
          if (m_busy[c] == 0) begin m_cnt[c] = m_init[c]; m_busy[c] = 1; end
          else if (fin) begin
            if (m_mode[c] == 1) m_cnt[c] = m_init[c];
            else begin m_cnt[c] = 0; m_busy[c] = 0; end
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (b_wr && b_addr == 8'(c * 4)) begin
          m_run[c] = b_wdata[30]; m_ien[c] = b_wdata[29];
          m_mode[c] = int'(b_wdata[28:27]); m_div[c] = int'(b_wdata[7:0]);
        end else if (fin && m_mode[c] != 1) m_run[c] = 0;
        if (b_wr && b_addr == 8'(8 + c * 4)) m_init[c] = int'(b_wdata[23:0]);
        if (fin) m_flag[c] = 1;
        else if (b_wr && b_addr == 8'h18 && b_wdata[c]) m_flag[c] = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #(CLK_NS/4);
    if (!rst && !done) begin
      string tag;
      case (b_addr)
        8'h14:        tag = "R4 live count";
        8'h18:        tag = "R7 flags";
        8'h00, 8'h04: tag = "R2 control";
        8'h08, 8'h0C: tag = "R10 start value";
        default:      tag = "R11 reserved read";
      endcase
      chk(tag, rdata, model_read(int'(b_addr)));
      chk("R8 irq", 32'(irq),
          32'((m_flag[0] & m_ien[0]) | ((m_flag[1] & m_ien[1]) << 1)));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    b_wr = 1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    b_wr = 0; b_addr = a; #1; v = rdata;
  endtask

  task automatic finish_up;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog got=timeout exp=completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, a;
    int t1, t2, guard;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    foreach (v[k]) begin end
    for (int x = 0; x < 32; x += 4) begin rd(8'(x), v); chk("R1 reset read", v, 0); end
    chk("R1 reset irq", 32'(irq), 0);
    // R2: readback and field masking
    @(negedge clk);
    wr(8'h04, 32'hB80000A5); rd(8'h04, v); chk("R2 ctrl readback", v, 32'h380000A5);
    wr(8'h0C, 32'hFFFFFFFF); rd(8'h0C, v); chk("R2 start value mask", v, 32'h00FFFFFF);
    // R11: reserved addresses
    wr(8'h10, 32'hFFFFFFFF); wr(8'h1C, 32'hFFFFFFFF); wr(8'h01, 32'hFFFFFFFF);
    rd(8'h10, v); chk("R11 reserved 0x10", v, 0);
    rd(8'h1C, v); chk("R11 reserved 0x1C", v, 0);
    rd(8'h00, v); chk("R11 ctrl0 untouched", v, 0);
    // R6: single-shot run of 5
    @(negedge clk);
    wr(8'h0C, 32'd5); wr(8'h04, 32'h40000000);
    repeat (12) @(negedge clk);
    rd(8'h14, v); chk("R6 count parked", v, 0);
    rd(8'h04, v); chk("R6 run cleared", v, 0);
    rd(8'h18, v); chk("R7 flag set with irq disabled", v, 2);
    chk("R8 irq masked", 32'(irq), 0);
    // R3/R5: auto-reload spacing, start 2, divider 3
    wr(8'h18, 32'h3); wr(8'h0C, 32'd2); wr(8'h04, 32'h68000003);
    guard = 0;
    do begin @(negedge clk); #1; guard++; end while (!irq[1] && guard < 100);
    t1 = cyc;
    wr(8'h18, 32'h2);
    guard = 0;
    do begin @(negedge clk); #1; guard++; end while (!irq[1] && guard < 100);
    t2 = cyc;
    chk("R3 R5 expiry spacing", 32'(t2 - t1), 32'(2 * (3 + 1)));
    // R8: disabling the interrupt masks the output but keeps the flag
    wr(8'h04, 32'h48000003); rd(8'h18, v);
    chk("R8 flag kept", v & 2, 2); chk("R8 irq off", 32'(irq[1]), 0);
    // R9: freeze and resume
    wr(8'h0C, 32'd100); wr(8'h04, 32'h48000000);
    repeat (10) @(negedge clk);
    wr(8'h04, 32'h08000000); rd(8'h14, a);
    repeat (5) @(negedge clk);
    rd(8'h14, v); chk("R9 frozen", v, a);
    wr(8'h04, 32'h48000000);
    repeat (3) @(negedge clk);
    rd(8'h14, v); chk("R9 resumed", v, a - 3);
    // R10: new start value does not disturb the current count
    wr(8'h0C, 32'd4); rd(8'h14, v); chk("R10 count kept", 32'(v > 4), 1);
    repeat (120) @(negedge clk);
    // R12: channel 0 alone
    wr(8'h04, 32'h0); wr(8'h18, 32'h3); rd(8'h14, a);
    wr(8'h08, 32'd3); wr(8'h00, 32'h68000000);
    guard = 0;
    do begin @(negedge clk); #1; guard++; end while (!irq[0] && guard < 100);
    chk("R12 only channel 0 fires", 32'(irq), 1);
    rd(8'h14, v); chk("R12 channel 1 count still", v, a);
    rd(8'h18, v); chk("R12 channel 1 flag clear", v, 1);
    // mixed random traffic, model compared every clock
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom;
      if (r % 10 < 3) begin
        logic [7:0] ad;
        logic [31:0] d;
        case ($urandom % 7)
          0: ad = 8'h00; 1: ad = 8'h04; 2: ad = 8'h08; 3: ad = 8'h0C;
          4: ad = 8'h18; 5: ad = 8'h14; default: ad = 8'h10;
        endcase
        if (ad == 8'h00 || ad == 8'h04)
          d = ($urandom & 32'h78000000) | ($urandom % 4);
        else if (ad == 8'h08 || ad == 8'h0C) d = $urandom % 13;
        else d = $urandom;
        wr(ad, d);
      end else begin
        case ($urandom % 4)
          0: b_addr = 8'h14; 1: b_addr = 8'h18; 2: b_addr = 8'h04; default: b_addr = 8'h00;
        endcase
        @(negedge clk);
      end
    end
    finish_up();
  end
endmodule